// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This combinational unit computes the result of one integer instruction in a 32-bit RISC pipeline. Each cycle the decode stage presents the primary opcode, the function code, the shift distance field, the two register operand values and the 16-bit immediate field. The unit produces a 32-bit result, a flag that is high when that result is zero, and a flag that marks encodings it does not implement.

The second operand is chosen inside the unit. It is either the second register value, the immediate with sign extension, or the immediate with zero extension, depending on the instruction. The operations covered are add, subtract, and, or, nor, the three shifts, signed set-on-less-than in register and immediate forms, and load-upper-immediate. For loads and stores the unit only forms the effective address as base plus offset. Register file access, memory access, branch decisions and overflow traps are handled elsewhere.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0x00, function 0x20 returns rs + rt and function 0x22 returns rs - rt, both modulo 2^32.
- R2: With opcode 0x00, function 0x24 returns rs AND rt, 0x25 returns rs OR rt, and 0x27 returns NOT (rs OR rt).
- R3: With opcode 0x00, function 0x00 shifts rt left, 0x02 shifts rt right filling with zeros, and 0x03 shifts rt right filling with bit 31 of rt. In all three the distance is the 5-bit shamt field, and a distance of 0 returns rt unchanged.
- R4: With opcode 0x00 and function 0x2A, the result is 1 when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Opcode 0x0A returns 1 when rs is less than the sign-extended immediate (signed compare), and 0 otherwise.
- R6: Opcode 0x08 returns rs plus the sign-extended immediate.
- R7: Opcode 0x0C returns rs AND the zero-extended immediate, and opcode 0x0D returns rs OR the zero-extended immediate.
- R8: Opcode 0x0F returns the immediate in bits 31:16 and zeros in bits 15:0.
- R9: Opcodes 0x20, 0x21, 0x23, 0x28, 0x29 and 0x2B return rs plus the sign-extended immediate.
- R10: The zero output is 1 exactly when all 32 result bits are 0.
- R11: Any opcode or function code not listed in R1 to R9 gives a result of 0 and an illegal output of 1. Every listed encoding gives illegal = 0.
- R12: Fields an instruction does not use have no effect on the result. For opcode 0x00 this is the immediate. For the immediate forms it is the function code, shamt and rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field, used when opcode is 0 |
| shamt | input | 5 | Shift distance field |
| rs_val | input | 32 | First register operand (base for memory ops) |
| rt_val | input | 32 | Second register operand (shift source) |
| imm16 | input | 16 | Immediate / offset field |
| result | output | 32 | Computed result |
| zero | output | 1 | High when result is all zeros |
| illegal | output | 1 | High for unsupported encodings |

## Verification
The unit holds no state, so any fault shows at the ports within the same evaluation as the stimulus. A decode fault routes the wrong operation or the wrong extension into the result mux. It therefore shows up where those choices differ: a negative immediate under zero versus sign extension, operands whose signed and unsigned order disagree, and right shifts of values with bit 31 set. For this reason the directed cases pick operands at those boundaries. They also vary unused fields and check that the result does not change.

// File: rtl/exec_pkg.sv
// Package: shared encodings and decoded-control types for the integer
// execution unit. Assumes the 32-bit fixed-format instruction layout.
package exec_pkg;

    // Primary opcodes
    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_SLTI    = 6'h0A;
    localparam logic [5:0] OPC_ANDI    = 6'h0C;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] OPC_LUI     = 6'h0F;
    localparam logic [5:0] OPC_LB      = 6'h20;
    localparam logic [5:0] OPC_LH      = 6'h21;
    localparam logic [5:0] OPC_LW      = 6'h23;
    localparam logic [5:0] OPC_SB      = 6'h28;
    localparam logic [5:0] OPC_SH      = 6'h29;
    localparam logic [5:0] OPC_SW      = 6'h2B;

    // Function codes under OPC_SPECIAL
    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_SRA = 6'h03;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
        OP_SLL, OP_SRL, OP_SRA, OP_SLT, OP_LUI, OP_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_REG, BSRC_SEXT, BSRC_ZEXT
    } bsrc_e;

    typedef struct packed {
        alu_op_e op;
        bsrc_e   bsrc;
        logic    illegal;
    } dec_ctl_t;

endpackage

// File: rtl/exec_decode.sv
// Module: exec_decode
// Maps opcode/function code to an internal operation, the second-operand
// source and an illegal flag. Assumes funct is meaningful only for opcode 0.
module exec_decode
    import exec_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output dec_ctl_t   ctl
);

    // Purpose: single-level decode of the instruction class and operation.
    always_comb begin
        ctl = '{op: OP_NONE, bsrc: BSRC_REG, illegal: 1'b0};
        if (opcode == OPC_SPECIAL) begin
            unique case (funct)
                FN_ADD:  ctl.op = OP_ADD;
                FN_SUB:  ctl.op = OP_SUB;
                FN_AND:  ctl.op = OP_AND;
                FN_OR:   ctl.op = OP_OR;
                FN_NOR:  ctl.op = OP_NOR;
                FN_SLL:  ctl.op = OP_SLL;
                FN_SRL:  ctl.op = OP_SRL;
                FN_SRA:  ctl.op = OP_SRA;
                FN_SLT:  ctl.op = OP_SLT;
                default: ctl.illegal = 1'b1;
            endcase
        end else begin
            unique case (opcode)
                OPC_ADDI: ctl = '{op: OP_ADD, bsrc: BSRC_SEXT, illegal: 1'b0};
                OPC_SLTI: ctl = '{op: OP_SLT, bsrc: BSRC_SEXT, illegal: 1'b0};
                OPC_ANDI: ctl = '{op: OP_AND, bsrc: BSRC_ZEXT, illegal: 1'b0};
                OPC_ORI:  ctl = '{op: OP_OR,  bsrc: BSRC_ZEXT, illegal: 1'b0};
                OPC_LUI:  ctl = '{op: OP_LUI, bsrc: BSRC_REG,  illegal: 1'b0};
                OPC_LB, OPC_LH, OPC_LW, OPC_SB, OPC_SH, OPC_SW:
                          ctl = '{op: OP_ADD, bsrc: BSRC_SEXT, illegal: 1'b0};
                default:  ctl.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/exec_operand.sv
// Module: exec_operand
// Selects the second operand: register value, sign-extended or
// zero-extended immediate. Assumes IMM_W < DATA_W.
module exec_operand
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  bsrc_e             bsrc,
    output logic [DATA_W-1:0] opb
);

    localparam int EXT_W = DATA_W - IMM_W;

    // Purpose: operand source mux with extension.
    always_comb begin
        unique case (bsrc)
            BSRC_SEXT: opb = {{EXT_W{imm[IMM_W-1]}}, imm};
            BSRC_ZEXT: opb = {{EXT_W{1'b0}}, imm};
            default:   opb = rt_val;
        endcase
    end

    // Purpose: guard the extension rules against the source operand.
    always_comb begin
        if (bsrc == BSRC_ZEXT)
            assert_zext_upper_R7: assert (opb[DATA_W-1:IMM_W] == '0);
        if (bsrc == BSRC_SEXT)
            assert_sext_upper_R6: assert (opb[DATA_W-1] == imm[IMM_W-1]);
    end

endmodule

// File: rtl/exec_shift.sv
// Module: exec_shift
// Logarithmic barrel shifter: left logical, right logical, right
// arithmetic. Left shifts reuse the right-shift stages on the bit-reversed
// input. Assumes DATA_W is a power of two.
module exec_shift #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    input  logic              arith,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] src_r;
    logic [DATA_W-1:0] stg [SH_W+1];
    logic              fill;

    // Purpose: reverse the input for left shifts; pick the fill bit.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            src_r[i] = left ? din[DATA_W-1-i] : din[i];
        fill = arith & ~left & din[DATA_W-1];
    end

    assign stg[0] = src_r;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stg[s+1] = amt[s] ? {{DIST{fill}}, stg[s][DATA_W-1:DIST]}
                                 : stg[s];
    end

    // Purpose: undo the reversal for left shifts.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            dout[i] = left ? stg[SH_W][DATA_W-1-i] : stg[SH_W][i];
    end

    // Purpose: zero distance is identity; arithmetic fill keeps sign.
    always_comb begin
        if (amt == '0)
            assert_shift_zero_R3: assert (dout == din);
        if (arith && !left && amt != '0)
            assert_sra_sign_R3: assert (dout[DATA_W-1] == din[DATA_W-1]);
    end

endmodule

// File: rtl/exec_arith.sv
// Module: exec_arith
// Adder/subtractor plus signed less-than compare. Assumes two's-complement
// operands; overflow is not reported.
module exec_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              lt
);

    // Purpose: shared add/subtract through inverted operand and carry-in.
    always_comb begin
        sum = a + (sub ? ~b : b) + {{(DATA_W-1){1'b0}}, sub};
        lt  = $signed(a) < $signed(b);
    end

    // Purpose: adding zero must leave the first operand intact.
    always_comb begin
        if (!sub && b == '0)
            assert_add_identity_R1: assert (sum == a);
    end

endmodule

// File: rtl/int_exec_unit.sv
// Module: int_exec_unit
// Top of the combinational integer execution unit: decodes the encoding,
// forms the second operand and muxes add/logic/shift/compare/upper-immediate
// results. Assumes the caller resolves branches, traps and memory access.
module int_exec_unit
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [5:0]        opcode,
    input  logic [5:0]        funct,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm16,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              illegal
);

    localparam int LOW_W = DATA_W - IMM_W;

    dec_ctl_t          ctl;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] shifted;
    logic              lt;

    exec_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctl    (ctl)
    );

    exec_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
        .rt_val (rt_val),
        .imm    (imm16),
        .bsrc   (ctl.bsrc),
        .opb    (opb)
    );

    exec_arith #(.DATA_W(DATA_W)) u_arith (
        .a   (rs_val),
        .b   (opb),
        .sub (ctl.op == OP_SUB || ctl.op == OP_SLT),
        .sum (sum),
        .lt  (lt)
    );

    exec_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .din   (rt_val),
        .amt   (shamt),
        .left  (ctl.op == OP_SLL),
        .arith (ctl.op == OP_SRA),
        .dout  (shifted)
    );

    // Purpose: final result selection by decoded operation.
    always_comb begin
        unique case (ctl.op)
            OP_ADD, OP_SUB:         result = sum;
            OP_AND:                 result = rs_val & opb;
            OP_OR:                  result = rs_val | opb;
            OP_NOR:                 result = ~(rs_val | opb);
            OP_SLL, OP_SRL, OP_SRA: result = shifted;
            OP_SLT:                 result = {{(DATA_W-1){1'b0}}, lt};
            OP_LUI:                 result = {imm16, {LOW_W{1'b0}}};
            default:                result = '0;
        endcase
    end

    assign zero    = (result == '0);
    assign illegal = ctl.illegal;

    // Purpose: cross-check the mux against decode outcomes.
    always_comb begin
        if (illegal)
            assert_illegal_clear_R11: assert (result == '0);
        if (ctl.op == OP_SLT)
            assert_slt_boolean_R4: assert (result[DATA_W-1:1] == '0);
        if (ctl.op == OP_LUI)
            assert_lui_low_clear_R8: assert (result[LOW_W-1:0] == '0);
    end

endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic [4:0]  shamt;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm16;
    logic [31:0] result;
    logic        zero;
    logic        illegal;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    int_exec_unit dut (
        .opcode (opcode), .funct (funct), .shamt (shamt),
        .rs_val (rs_val), .rt_val (rt_val), .imm16 (imm16),
        .result (result), .zero (zero), .illegal (illegal)
    );

    task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                         input logic [4:0] sa, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im);
        @(posedge clk);
        opcode = op; funct = fn; shamt = sa;
        rs_val = a;  rt_val = b; imm16 = im;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp_res,
                         input logic exp_ill);
        n_cmp++;
        if (result !== exp_res || zero !== (exp_res == 32'h0)
            || illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: result=%h zero=%b illegal=%b expected result=%h zero=%b illegal=%b",
                     req, result, zero, illegal, exp_res, exp_res == 32'h0, exp_ill);
        end
    endtask

    task automatic t_reset_state();
        drive(6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0);
        check("R10 idle inputs", 32'h0, 1'b0);
    endtask

    task automatic t_add_sub();   // R1
        drive(6'h00, 6'h20, 5'd0, 32'd5, 32'd7, 16'h0);
        check("R1 add", 32'd12, 1'b0);
        drive(6'h00, 6'h20, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0);
        check("R1 add wrap", 32'h0, 1'b0);
        drive(6'h00, 6'h22, 5'd0, 32'd3, 32'd5, 16'h0);
        check("R1 sub negative", 32'hFFFF_FFFE, 1'b0);
        drive(6'h00, 6'h22, 5'd0, 32'h1234_5678, 32'h1234_5678, 16'h0);
        check("R1 sub equal", 32'h0, 1'b0);
    endtask

    task automatic t_logic();     // R2
        drive(6'h00, 6'h24, 5'd0, 32'hF0F0_FF00, 32'hFF00_0FF0, 16'h0);
        check("R2 and", 32'hF000_0F00, 1'b0);
        drive(6'h00, 6'h25, 5'd0, 32'hF0F0_FF00, 32'h0F00_00F0, 16'h0);
        check("R2 or", 32'hFFF0_FFF0, 1'b0);
        drive(6'h00, 6'h27, 5'd0, 32'h0, 32'h0, 16'h0);
        check("R2 nor zeros", 32'hFFFF_FFFF, 1'b0);
        drive(6'h00, 6'h27, 5'd0, 32'hF000_0000, 32'h0000_000F, 16'h0);
        check("R2 nor mix", 32'h0FFF_FFF0, 1'b0);
    endtask

    task automatic t_shift();     // R3
        drive(6'h00, 6'h00, 5'd31, 32'h0, 32'h1, 16'h0);
        check("R3 sll 31", 32'h8000_0000, 1'b0);
        drive(6'h00, 6'h02, 5'd4, 32'h0, 32'h8000_0000, 16'h0);
        check("R3 srl zero fill", 32'h0800_0000, 1'b0);
        drive(6'h00, 6'h03, 5'd4, 32'h0, 32'h8000_0000, 16'h0);
        check("R3 sra sign fill", 32'hF800_0000, 1'b0);
        drive(6'h00, 6'h03, 5'd31, 32'h0, 32'h7FFF_FFFF, 16'h0);
        check("R3 sra positive", 32'h0, 1'b0);
        drive(6'h00, 6'h02, 5'd0, 32'h0, 32'hA5A5_1234, 16'h0);
        check("R3 shamt zero", 32'hA5A5_1234, 1'b0);
        drive(6'h00, 6'h00, 5'd8, 32'h0, 32'h00AB_CDEF, 16'h0);
        check("R3 sll 8", 32'hABCD_EF00, 1'b0);
    endtask

    task automatic t_slt();       // R4
        drive(6'h00, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0);
        check("R4 slt neg<pos", 32'd1, 1'b0);
        drive(6'h00, 6'h2A, 5'd0, 32'd1, 32'hFFFF_FFFF, 16'h0);
        check("R4 slt pos<neg", 32'd0, 1'b0);
        drive(6'h00, 6'h2A, 5'd0, 32'd9, 32'd9, 16'h0);
        check("R4 slt equal", 32'd0, 1'b0);
    endtask

    task automatic t_slti();      // R5
        drive(6'h0A, 6'h00, 5'd0, 32'd5, 32'h0, 16'hFFFF);
        check("R5 slti 5<-1", 32'd0, 1'b0);
        drive(6'h0A, 6'h00, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF);
        check("R5 slti -2<-1", 32'd1, 1'b0);
        drive(6'h0A, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0001);
        check("R5 slti 0<1", 32'd1, 1'b0);
    endtask

    task automatic t_addi();      // R6
        drive(6'h08, 6'h00, 5'd0, 32'd10, 32'h0, 16'hFFFF);
        check("R6 addi -1", 32'd9, 1'b0);
        drive(6'h08, 6'h00, 5'd0, 32'h0, 32'h0, 16'h8000);
        check("R6 addi sext", 32'hFFFF_8000, 1'b0);
    endtask

    task automatic t_logic_imm(); // R7
        drive(6'h0C, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001);
        check("R7 andi zext", 32'h0000_8001, 1'b0);
        drive(6'h0D, 6'h00, 5'd0, 32'h0, 32'h0, 16'hFFFF);
        check("R7 ori zext", 32'h0000_FFFF, 1'b0);
        drive(6'h0C, 6'h00, 5'd0, 32'hFFFF_0000, 32'h0, 16'hFFFF);
        check("R7 andi to zero", 32'h0, 1'b0);
    endtask

    task automatic t_lui();       // R8
        drive(6'h0F, 6'h00, 5'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'h1234);
        check("R8 lui", 32'h1234_0000, 1'b0);
        drive(6'h0F, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h0);
        check("R8 lui zero imm", 32'h0, 1'b0);
    endtask

    task automatic t_mem_addr();  // R9
        logic [5:0] ops [6] = '{6'h20, 6'h21, 6'h23, 6'h28, 6'h29, 6'h2B};
        for (int i = 0; i < 6; i++) begin
            drive(ops[i], 6'h00, 5'd0, 32'h1000_0000, 32'h0, 16'hFFFC);
            check($sformatf("R9 mem op %h neg offset", ops[i]), 32'h0FFF_FFFC, 1'b0);
            drive(ops[i], 6'h00, 5'd0, 32'h1000_0000, 32'h0, 16'h0064);
            check($sformatf("R9 mem op %h pos offset", ops[i]), 32'h1000_0064, 1'b0);
        end
    endtask

    task automatic t_zero_flag(); // R10
        drive(6'h00, 6'h24, 5'd0, 32'hAAAA_AAAA, 32'h5555_5555, 16'h0);
        check("R10 and disjoint", 32'h0, 1'b0);
        drive(6'h00, 6'h20, 5'd0, 32'h0, 32'h0000_0001, 16'h0);
        check("R10 nonzero lsb", 32'h1, 1'b0);
    endtask

    task automatic t_illegal();   // R11
        drive(6'h02, 6'h20, 5'd0, 32'd5, 32'd7, 16'h1234);
        check("R11 bad opcode", 32'h0, 1'b1);
        drive(6'h00, 6'h08, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
        check("R11 bad funct 08", 32'h0, 1'b1);
        drive(6'h00, 6'h01, 5'd1, 32'h1, 32'h1, 16'h0);
        check("R11 bad funct 01", 32'h0, 1'b1);
        drive(6'h22, 6'h00, 5'd0, 32'h1, 32'h1, 16'h1);
        check("R11 unlisted load", 32'h0, 1'b1);
    endtask

    task automatic t_unused();    // R12
        drive(6'h00, 6'h20, 5'd0, 32'd100, 32'd23, 16'hFFFF);
        check("R12 add ignores imm", 32'd123, 1'b0);
        drive(6'h00, 6'h25, 5'd17, 32'h0000_00F0, 32'h0000_000F, 16'h8000);
        check("R12 or ignores shamt/imm", 32'h0000_00FF, 1'b0);
        drive(6'h08, 6'h2A, 5'd31, 32'd100, 32'hFFFF_FFFF, 16'd23);
        check("R12 addi ignores funct/shamt/rt", 32'd123, 1'b0);
        drive(6'h0D, 6'h27, 5'd9, 32'h0, 32'hFFFF_FFFF, 16'h0001);
        check("R12 ori ignores rt", 32'h1, 1'b0);
    endtask

    initial begin
        opcode = '0; funct = '0; shamt = '0;
        rs_val = '0; rt_val = '0; imm16 = '0;
        t_reset_state();
        t_add_sub();
        t_logic();
        t_shift();
        t_slt();
        t_slti();
        t_addi();
        t_logic_imm();
        t_lui();
        t_mem_addr();
        t_zero_flag();
        t_illegal();
        t_unused();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule